// File: doc/BRIEF.md
# DRAM Refresh Request Timer

This block paces DRAM refresh from a fast delay-line clock. A programmable prescaler divides the incoming clock down to roughly 2 MHz. A second divider, tuned by a single bit, stretches that rate to one refresh interval of about 13 or 15 microseconds. At the end of each interval the block raises a refresh request flag. The flag stays up until the refresh engine reports a completed refresh. The same report advances an 11-bit row pointer that walks the whole array. A separate strobe can force that pointer back to zero.

The timer stays idle until configuration is loaded for the first time. That first load after reset also opens a warm-up window, during which the block refreshes on its own once per interval and advances the row pointer without asking for arbitration. A warm-up indicator stays high for the whole window. Loading configuration again changes the rates and restarts both dividers, but it does not reopen the window. Only a new reset re-arms it.

The pins are plain control and status lines. No data stream crosses this block, so it has no valid/ready channel and no back-pressure.

Top module: `rfsh_timer`

## Requirements
- R1: After reset `rfsh_req_o`, `row_o` and `warmup_o` are 0. Until the first `cfg_load_i` pulse, no request is raised however long the clock runs.
- R2: The prescale code `cfg_pre_sel_i` selects a division of 10 minus the code: code 0 divides by 10 and code 7 divides by 3, one step per code.
- R3: `cfg_fine_i` = 0 adds a further division by 30 and `cfg_fine_i` = 1 a division by 26. Requests then arrive every prescale × fine clock cycles. The first one becomes visible exactly that many cycles after the edge that samples `cfg_load_i`.
- R4: A raised request stays high until `rfsh_done_i` is sampled. If the end of an interval and a done strobe fall on the same edge, the request stays high.
- R5: Outside the warm-up window, each cycle with `rfsh_done_i` high advances `row_o` by one, modulo 2048, so 2047 wraps to 0.
- R6: `cnt_clr_i` sets `row_o` to 0 on the next edge and takes priority over a simultaneous done strobe.
- R7: The first `cfg_load_i` after reset opens a warm-up window of `INIT_INTERVALS` intervals (default 4096, so 4096 × prescale × fine clocks). During the window `warmup_o` is high, no request is raised, `row_o` advances once per interval, and `rfsh_done_i` has no effect. The first normal request follows one interval after the window closes.
- R8: A later `cfg_load_i` applies the new ratios and restarts both dividers, but `warmup_o` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Delay-line clock; all counting runs on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_load_i | input | 1 | One-cycle strobe that loads the two configuration fields |
| cfg_pre_sel_i | input | 3 | Prescale code, ratio = 10 − code |
| cfg_fine_i | input | 1 | Interval divider select: 0 → 30, 1 → 26 |
| rfsh_done_i | input | 1 | A refresh finished; clears the request and advances the row |
| cnt_clr_i | input | 1 | Force the row pointer to zero |
| rfsh_req_o | output | 1 | Refresh request flag |
| row_o | output | ROW_W | Refresh row pointer |
| warmup_o | output | 1 | High during the post-configuration warm-up window |

## Verification
The main function is driven with all sixteen combinations of prescale code and fine bit. The timing of the first request after a load separates a wrong divider restart from a wrong ratio. The spacing of the second request separates a prescale mapping error from an error in the fine divider. A request left unanswered across a full interval, with done arriving on the very edge that ends the next interval, separates set-over-clear priority from the reverse. A long done burst across 2047 exposes the wrap. The warm-up window is run twice, around a mid-run reset. This shows that only the first load after each reset opens it, and that done pulses inside it are ignored.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;
  localparam int SEL_W     = 3;
  localparam int PRE_W     = 4;
  localparam int FINE_W    = 5;
  localparam int PRE_BASE  = 10;
  localparam int FINE_SLOW = 30;
  localparam int FINE_FAST = 26;

  typedef logic [SEL_W-1:0]  sel_t;
  typedef logic [PRE_W-1:0]  pre_ratio_t;
  typedef logic [FINE_W-1:0] fine_ratio_t;

  function automatic pre_ratio_t pre_ratio(input sel_t code);
    return pre_ratio_t'(PRE_BASE) - pre_ratio_t'(code);
  endfunction

  function automatic fine_ratio_t fine_ratio(input logic fast);
    return fast ? fine_ratio_t'(FINE_FAST) : fine_ratio_t'(FINE_SLOW);
  endfunction
endpackage

// File: rtl/rfsh_div.sv
module rfsh_div #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         restart_i,
  input  logic         en_i,
  input  logic [W-1:0] ratio_i,
  output logic         tick_o
);
  logic [W-1:0] cnt_q;
  logic         at_end;

  assign at_end = (cnt_q == ratio_i - W'(1));
  assign tick_o = en_i && !restart_i && at_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (restart_i) begin
      cnt_q <= '0;
    end else if (en_i) begin
      cnt_q <= at_end ? '0 : cnt_q + W'(1);
    end
  end
endmodule

// File: rtl/rfsh_cfg_ctrl.sv
module rfsh_cfg_ctrl
  import rfsh_pkg::*;
#(
  parameter int INIT_INTERVALS = 4096
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        load_i,
  input  sel_t        sel_i,
  input  logic        fine_i,
  input  logic        itv_tick_i,
  output logic        running_o,
  output pre_ratio_t  pre_ratio_o,
  output fine_ratio_t fine_ratio_o,
  output logic        warmup_o
);
  localparam int INIT_W = (INIT_INTERVALS > 1) ? $clog2(INIT_INTERVALS) : 1;
  localparam logic [INIT_W-1:0] INIT_LAST = INIT_W'(INIT_INTERVALS - 1);

  sel_t              sel_q;
  logic              fine_q;
  logic              done_once_q;
  logic              warm_q;
  logic [INIT_W-1:0] warm_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q       <= '0;
      fine_q      <= 1'b0;
      done_once_q <= 1'b0;
    end else if (load_i) begin
      sel_q       <= sel_i;
      fine_q      <= fine_i;
      done_once_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      warm_q     <= 1'b0;
      warm_cnt_q <= '0;
    end else if (load_i && !done_once_q) begin
      warm_q     <= 1'b1;
      warm_cnt_q <= '0;
    end else if (warm_q && itv_tick_i) begin
      if (warm_cnt_q == INIT_LAST) begin
        warm_q <= 1'b0;
      end else begin
        warm_cnt_q <= warm_cnt_q + INIT_W'(1);
      end
    end
  end

  assign running_o    = done_once_q;
  assign pre_ratio_o  = pre_ratio(sel_q);
  assign fine_ratio_o = fine_ratio(fine_q);
  assign warmup_o     = warm_q;
endmodule

// File: rtl/rfsh_row_ctr.sv
module rfsh_row_ctr #(
  parameter int W = 11
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] row_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_o <= '0;
    end else if (clr_i) begin
      row_o <= '0;
    end else if (inc_i) begin
      row_o <= row_o + W'(1);
    end
  end
endmodule

// File: rtl/rfsh_timer.sv
module rfsh_timer
  import rfsh_pkg::*;
#(
  parameter int ROW_W          = 11,
  parameter int INIT_INTERVALS = 4096
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_load_i,
  input  logic [2:0]       cfg_pre_sel_i,
  input  logic             cfg_fine_i,
  input  logic             rfsh_done_i,
  input  logic             cnt_clr_i,
  output logic             rfsh_req_o,
  output logic [ROW_W-1:0] row_o,
  output logic             warmup_o
);
  logic        running;
  pre_ratio_t  pre_r;
  fine_ratio_t fine_r;
  logic        pre_tick;
  logic        itv_tick;
  logic        warm;
  logic        row_inc;
  logic        req_q;

  rfsh_cfg_ctrl #(.INIT_INTERVALS(INIT_INTERVALS)) u_cfg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (cfg_load_i),
    .sel_i       (cfg_pre_sel_i),
    .fine_i      (cfg_fine_i),
    .itv_tick_i  (itv_tick),
    .running_o   (running),
    .pre_ratio_o (pre_r),
    .fine_ratio_o(fine_r),
    .warmup_o    (warm)
  );

  rfsh_div #(.W(PRE_W)) u_pre (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .restart_i(cfg_load_i),
    .en_i     (running),
    .ratio_i  (pre_r),
    .tick_o   (pre_tick)
  );

  rfsh_div #(.W(FINE_W)) u_fine (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .restart_i(cfg_load_i),
    .en_i     (pre_tick),
    .ratio_i  (fine_r),
    .tick_o   (itv_tick)
  );

  assign row_inc = warm ? itv_tick : rfsh_done_i;

  rfsh_row_ctr #(.W(ROW_W)) u_row (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (cnt_clr_i),
    .inc_i (row_inc),
    .row_o (row_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= 1'b0;
    end else if (itv_tick && !warm) begin
      req_q <= 1'b1;
    end else if (rfsh_done_i) begin
      req_q <= 1'b0;
    end
  end

  assign rfsh_req_o = req_q;
  assign warmup_o   = warm;
endmodule

// File: rtl/rfsh_timer_chk.sv
module rfsh_timer_chk #(
  parameter int ROW_W = 11
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cfg_load_i,
  input logic             rfsh_done_i,
  input logic             cnt_clr_i,
  input logic             rfsh_req_o,
  input logic [ROW_W-1:0] row_o,
  input logic             warmup_o
);
  logic loaded_q;
  logic warm_prev_q;
  logic warm_over_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      loaded_q    <= 1'b0;
      warm_prev_q <= 1'b0;
      warm_over_q <= 1'b0;
    end else begin
      loaded_q    <= loaded_q | cfg_load_i;
      warm_prev_q <= warmup_o;
      warm_over_q <= warm_over_q | (warm_prev_q & !warmup_o);
    end
  end

  // R1: no request before any configuration load
  p_idle_unloaded_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !loaded_q |-> !rfsh_req_o);

  // R4: request held until done
  p_req_held_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rfsh_req_o && !rfsh_done_i) |=> rfsh_req_o);

  // R5: done advances the row outside warm-up
  p_row_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rfsh_done_i && !cnt_clr_i && !warmup_o) |=> row_o == ROW_W'($past(row_o) + 1'b1));

  // R6: clear strobe zeroes the row
  p_row_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_clr_i |=> row_o == '0);

  // R7: no request inside warm-up
  p_quiet_warmup_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warmup_o |-> !rfsh_req_o);

  // R8: warm-up never reopens before the next reset
  p_warmup_once_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warm_over_q |-> !warmup_o);
endmodule

bind rfsh_timer rfsh_timer_chk #(.ROW_W(ROW_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cfg_load_i (cfg_load_i),
  .rfsh_done_i(rfsh_done_i),
  .cnt_clr_i  (cnt_clr_i),
  .rfsh_req_o (rfsh_req_o),
  .row_o      (row_o),
  .warmup_o   (warmup_o)
);

// File: tb/sim_rfsh_timer.sv
`timescale 1ns/1ps
module sim_rfsh_timer;
  localparam int ROW_W = 11;
  localparam int WARM  = 4;

  // {prescale code, fine bit, expected interval in clocks}
  localparam logic [12:0] VEC [16] = '{
    {3'd0, 1'b0, 9'd300}, {3'd0, 1'b1, 9'd260},
    {3'd1, 1'b0, 9'd270}, {3'd1, 1'b1, 9'd234},
    {3'd2, 1'b0, 9'd240}, {3'd2, 1'b1, 9'd208},
    {3'd3, 1'b0, 9'd210}, {3'd3, 1'b1, 9'd182},
    {3'd4, 1'b0, 9'd180}, {3'd4, 1'b1, 9'd156},
    {3'd5, 1'b0, 9'd150}, {3'd5, 1'b1, 9'd130},
    {3'd6, 1'b0, 9'd120}, {3'd6, 1'b1, 9'd104},
    {3'd7, 1'b0, 9'd90},  {3'd7, 1'b1, 9'd78}
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             load = 1'b0;
  logic [2:0]       sel = '0;
  logic             fine = 1'b0;
  logic             done = 1'b0;
  logic             clr = 1'b0;
  logic             req;
  logic [ROW_W-1:0] row;
  logic             warm;

  int cyc = 0;
  int n_tests = 0;
  int n_fail = 0;
  int exp_row = 0;
  int t_load = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rfsh_timer #(.ROW_W(ROW_W), .INIT_INTERVALS(WARM)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_load_i(load), .cfg_pre_sel_i(sel),
    .cfg_fine_i(fine), .rfsh_done_i(done), .cnt_clr_i(clr),
    .rfsh_req_o(req), .row_o(row), .warmup_o(warm)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic load_cfg(input logic [2:0] s, input logic f);
    @(negedge clk);
    sel = s; fine = f; load = 1'b1;
    @(negedge clk);
    load = 1'b0;
    t_load = cyc;
  endtask

  task automatic wait_req(output int t);
    while (!req) @(negedge clk);
    t = cyc;
  endtask

  task automatic pulse_done();
    @(negedge clk); done = 1'b1;
    @(negedge clk); done = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    report();
  end

  initial begin
    int t1, t2, per, pf;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 reset req", int'(req), 0);
    chk("R1 reset row", int'(row), 0);
    chk("R1 reset warmup", int'(warm), 0);
    repeat (400) @(negedge clk);
    chk("R1 no request before config", int'(req), 0);

    // warm-up after first load: P=3, F=26
    pf = 78;
    load_cfg(3'd7, 1'b1);
    chk("R7 warmup opens", int'(warm), 1);
    wait_until(t_load + 10);
    done = 1'b1;
    @(negedge clk); done = 1'b0;
    wait_until(t_load + WARM*pf - 1);
    chk("R7 warmup still open", int'(warm), 1);
    chk("R7 row during warmup, done ignored", int'(row), WARM-1);
    chk("R7 no request in warmup", int'(req), 0);
    @(negedge clk);
    chk("R7 warmup closed", int'(warm), 0);
    chk("R7 row after warmup", int'(row), WARM);
    exp_row = WARM;
    wait_req(t1);
    chk("R7 first request after warmup", t1 - t_load, (WARM+1)*pf);
    pulse_done();
    exp_row++;
    chk("R4 done clears request", int'(req), 0);

    // period table
    for (int i = 0; i < 16; i++) begin
      per = int'(VEC[i][8:0]);
      load_cfg(VEC[i][12:10], VEC[i][9]);
      chk("R8 reload keeps warmup low", int'(warm), 0);
      wait_req(t1);
      chk("R3 first request delay", t1 - t_load, per);
      pulse_done();
      wait_req(t2);
      chk("R2 request period", t2 - t1, per);
      pulse_done();
      exp_row += 2;
    end
    chk("R5 row after table", int'(row), exp_row % 2048);

    // request held, tick and done on the same edge (P=3, F=26)
    wait_req(t1);
    wait_until(t1 + 40);
    chk("R4 request held without done", int'(req), 1);
    wait_until(t1 + 77);
    done = 1'b1;
    @(negedge clk); done = 1'b0;
    exp_row++;
    chk("R4 tick beats done", int'(req), 1);
    chk("R5 row on coincident done", int'(row), exp_row % 2048);
    pulse_done();
    chk("R4 later done clears", int'(req), 0);

    // clear priority and wrap
    @(negedge clk); clr = 1'b1; done = 1'b1;
    @(negedge clk); clr = 1'b0; done = 1'b0;
    chk("R6 clear beats done", int'(row), 0);
    @(negedge clk); done = 1'b1;
    repeat (2047) @(negedge clk);
    done = 1'b0;
    chk("R5 row reaches top", int'(row), 2047);
    pulse_done();
    chk("R5 row wraps to zero", int'(row), 0);

    // mid-run reset re-arms warm-up
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk("R1 reset clears request", int'(req), 0);
    chk("R1 reset clears row", int'(row), 0);
    rst_n = 1'b1;
    repeat (300) @(negedge clk);
    chk("R1 idle after reset", int'(req), 0);
    pf = 104;
    load_cfg(3'd6, 1'b1);
    chk("R7 warmup re-armed by reset", int'(warm), 1);
    wait_until(t_load + WARM*pf);
    chk("R7 second warmup closes", int'(warm), 0);
    chk("R7 second warmup rows", int'(row), WARM);
    report();
  end
endmodule